// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes that an 8051-style core presents to external memory. The address-latch strobe (`ale_o`, active high) lets an external latch capture the low address byte. The program-store read strobe (`psen_no`, active low) reads code from an external program memory. The oscillator clock is divided into machine cycles of six states. Each state lasts two clocks, so a machine cycle is twelve clocks long. Each machine cycle has two strobe slots, and each slot holds one ALE pulse followed by one PSEN activation.

The core controls the pattern through three plain control pins:
- `code_ext` enables PSEN activations while code executes from external program memory.
- `xmem_cycle` marks a machine cycle that performs an external data access. That cycle drops its first PSEN activation, and the next machine cycle drops its first ALE pulse.
- `ale_disable` keeps ALE low.

The block has no data stream, so it has no valid/ready interface.

Timing is counted in clock phases 0 to 11 within a machine cycle. State 1 covers phases 0 and 1, state 2 covers phases 2 and 3, and so on. Both outputs are registered. After the clock edge that moves the cycle to phase k, the outputs show the pattern for phase k.

Top module: `bus_strobe_gen`

## Requirements
- R1: A machine cycle is 12 clocks. `ale_o` is high in phases 1-2 and 7-8 and low in all other phases.
- R2: With `code_ext` high, `psen_no` is low for 3 clocks starting one clock after ALE falls. These are phases 4-6 for the first slot, and phases 10, 11 and phase 0 of the next cycle for the second slot. ALE and PSEN are never active together.
- R3: A PSEN activation occurs only if `code_ext` was high at the edge that starts it. With `code_ext` low, `psen_no` stays high.
- R4: `xmem_cycle` is sampled at the edge that enters phase 0. When it was high, that machine cycle omits its first PSEN activation (phases 4-6) and keeps the second one.
- R5: In the machine cycle after a cycle flagged by `xmem_cycle`, the first ALE pulse (phases 1-2) is omitted. The second pulse is kept.
- R6: When `ale_disable` is high at a clock edge, `ale_o` is low after that edge, whatever the phase.
- R7: Reset is synchronous. While `rst` is high, `ale_o` and `psen_no` are both high. The first edge after `rst` falls enters phase 0 of a new machine cycle, and no activation is carried over from before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| code_ext | input | 1 | Code is fetched from external program memory |
| xmem_cycle | input | 1 | Current machine cycle performs an external data access |
| ale_disable | input | 1 | Forces the address-latch strobe inactive |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_no | output | 1 | Program-store read strobe, active low |

## Verification
The checker tests these properties on every cycle:
- the width limits of both strobes;
- that the strobes never overlap;
- that ALE is silenced when `ale_disable` is high;
- that PSEN falls only under an external-fetch request;
- the idle levels during reset.

Some behaviour needs knowledge across machine cycles and only the bench's sweep shows it. This covers the exact phase positions, the dropping of the first PSEN slot in a flagged cycle, and the dropping of the first ALE slot in the cycle that follows. The sweep walks every combination of the three control pins, together with the flag from the previous cycle, across two reset releases.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef struct packed {
    logic ale;
    logic psen_n;
  } strobe_t;

  // True when phase ph falls in the circular window [start, start+len) modulo period.
  function automatic logic in_window(int ph, int start, int len, int period);
    int off;
    off = (ph + period - start) % period;
    return (off < len);
  endfunction

endpackage

// File: rtl/mc_phase_seq.sv
module mc_phase_seq #(
  parameter int MC_CLKS = 12,
  parameter int PH_W    = 4
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase_nxt,
  output logic            mc_start
);
  localparam logic [PH_W-1:0] LAST = PH_W'(MC_CLKS - 1);

  logic [PH_W-1:0] phase_q;

  always_comb begin
    if (phase_q == LAST) phase_nxt = '0;
    else                 phase_nxt = phase_q + 1'b1;
    mc_start = (phase_nxt == '0);
  end

  // Parked on the last phase during reset so the first edge after release enters phase 0.
  always_ff @(posedge clk) begin
    if (rst) phase_q <= LAST;
    else     phase_q <= phase_nxt;
  end
endmodule

// File: rtl/mc_context.sv
module mc_context (
  input  logic clk,
  input  logic rst,
  input  logic mc_start,
  input  logic xmem_in,
  output logic xd_cur,
  output logic xd_prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xd_cur  <= 1'b0;
      xd_prev <= 1'b0;
    end else if (mc_start) begin
      xd_cur  <= xmem_in;
      xd_prev <= xd_cur;
    end
  end
endmodule

// File: rtl/strobe_shaper.sv
module strobe_shaper
  import strobe_pkg::*;
#(
  parameter int CPS      = 2,
  parameter int SPM      = 6,
  parameter int PSEN_LEN = 3,
  parameter int PH_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase_nxt,
  input  logic            code_ext,
  input  logic            xd_cur,
  input  logic            xd_prev,
  input  logic            ale_disable,
  output logic            ale_o,
  output logic            psen_no
);
  localparam int MC_CLKS = CPS * SPM;
  localparam int NSLOT   = 2;
  localparam int SLOT_STATE [NSLOT] = '{0, 3};

  logic [NSLOT-1:0] ale_win;
  logic [NSLOT-1:0] psen_act;
  strobe_t          nxt;
  int               ph;

  assign ph = int'(phase_nxt);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int  ALE_ST  = SLOT_STATE[i] * CPS + CPS / 2;
    localparam int  PS_ST   = (ALE_ST + CPS + 1) % MC_CLKS;
    localparam bit  FIRST   = (i == 0);

    logic en_q;
    logic en_d;

    always_comb begin
      ale_win[i] = in_window(ph, ALE_ST, CPS, MC_CLKS) && !(FIRST && xd_prev);
      if (ph == PS_ST) en_d = code_ext && !(FIRST && xd_cur);
      else             en_d = en_q;
      psen_act[i] = in_window(ph, PS_ST, PSEN_LEN, MC_CLKS) && en_d;
    end

    // Slot enable is held from its start phase so a window may cross into the next cycle.
    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= en_d;
    end
  end

  always_comb begin
    nxt.ale    = !ale_disable && (|ale_win);
    nxt.psen_n = !(|psen_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o   <= 1'b1;
      psen_no <= 1'b1;
    end else begin
      ale_o   <= nxt.ale;
      psen_no <= nxt.psen_n;
    end
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int CPS      = 2,
  parameter int SPM      = 6,
  parameter int PSEN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic code_ext,
  input  logic xmem_cycle,
  input  logic ale_disable,
  output logic ale_o,
  output logic psen_no
);
  localparam int MC_CLKS = CPS * SPM;
  localparam int PH_W    = $clog2(MC_CLKS);

  logic [PH_W-1:0] phase_nxt;
  logic            mc_start;
  logic            xd_cur;
  logic            xd_prev;

  mc_phase_seq #(.MC_CLKS(MC_CLKS), .PH_W(PH_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .mc_start  (mc_start)
  );

  mc_context u_ctx (
    .clk      (clk),
    .rst      (rst),
    .mc_start (mc_start),
    .xmem_in  (xmem_cycle),
    .xd_cur   (xd_cur),
    .xd_prev  (xd_prev)
  );

  strobe_shaper #(.CPS(CPS), .SPM(SPM), .PSEN_LEN(PSEN_LEN), .PH_W(PH_W)) u_shape (
    .clk         (clk),
    .rst         (rst),
    .phase_nxt   (phase_nxt),
    .code_ext    (code_ext),
    .xd_cur      (xd_cur),
    .xd_prev     (xd_prev),
    .ale_disable (ale_disable),
    .ale_o       (ale_o),
    .psen_no     (psen_no)
  );
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk (
  input logic clk,
  input logic rst,
  input logic code_ext,
  input logic ale_disable,
  input logic ale_o,
  input logic psen_no
);
  logic [2:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)              low_run <= '0;
    else if (!psen_no)    low_run <= (low_run == 3'd7) ? low_run : low_run + 1'b1;
    else                  low_run <= '0;
  end

  // R1: an ALE pulse never lasts more than two clocks
  assert_ale_width_R1: assert property (@(posedge clk) disable iff (rst)
    (ale_o && $past(ale_o)) |=> !ale_o);

  // R2: a PSEN activation never lasts more than three clocks
  assert_psen_width_R2: assert property (@(posedge clk) disable iff (rst)
    low_run <= 3'd3);

  // R2: the two strobes are never active together
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(ale_o && !psen_no));

  // R3: PSEN only starts an activation under an external fetch request
  assert_psen_internal_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_no) |-> $past(code_ext));

  // R6: disable bit silences ALE at the following edge
  assert_ale_off_R6: assert property (@(posedge clk) disable iff (rst)
    ale_disable |=> !ale_o);

  // R7: both strobes idle high after a reset edge
  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> (ale_o && psen_no));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .code_ext    (code_ext),
  .ale_disable (ale_disable),
  .ale_o       (ale_o),
  .psen_no     (psen_no)
);

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/100ps
module bus_strobe_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic code_ext = 1'b0;
  logic xmem_cycle = 1'b0;
  logic ale_disable = 1'b0;
  logic ale_o;
  logic psen_no;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_strobe_gen uut (
    .clk         (clk),
    .rst         (rst),
    .code_ext    (code_ext),
    .xmem_cycle  (xmem_cycle),
    .ale_disable (ale_disable),
    .ale_o       (ale_o),
    .psen_no     (psen_no)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] pattern(int k, int salt);
    return 3'((k * 5 + k / 8 + salt) % 8);
  endfunction

  task automatic drive(logic [2:0] code);
    code_ext    = code[0];
    xmem_cycle  = code[1];
    ale_disable = code[2];
  endtask

  // Called at a negedge while rst is high: releases reset and sweeps n machine cycles.
  task automatic sweep(int n, int salt);
    logic cur_e, cur_x, cur_a, prev_e, prev_x;
    logic exp_ale, exp_psen_n;
    string tag_a, tag_p;
    logic [2:0] c;
    c = pattern(0, salt);
    drive(c);
    cur_e = c[0]; cur_x = c[1]; cur_a = c[2];
    prev_e = 1'b0; prev_x = 1'b0;
    rst = 1'b0;
    for (int m = 0; m < n; m++) begin
      for (int p = 0; p < 12; p++) begin
        @(negedge clk);
        exp_ale = !cur_a && (((p == 1 || p == 2) && !prev_x) || p == 7 || p == 8);
        exp_psen_n = !(((p >= 4 && p <= 6) && cur_e && !cur_x) ||
                       ((p == 10 || p == 11) && cur_e) ||
                       (p == 0 && prev_e));
        if (cur_a)                              tag_a = "R6";
        else if ((p == 1 || p == 2) && prev_x)  tag_a = "R5";
        else                                    tag_a = "R1";
        if (p >= 4 && p <= 6 && cur_x)          tag_p = "R4";
        else if (exp_psen_n)                    tag_p = "R3";
        else                                    tag_p = "R2";
        check(tag_a, $sformatf("ale cyc%0d ph%0d", m, p), ale_o, exp_ale);
        check(tag_p, $sformatf("psen_n cyc%0d ph%0d", m, p), psen_no, exp_psen_n);
        if (p == 11) begin
          prev_e = cur_e; prev_x = cur_x;
          c = pattern(m + 1, salt);
          drive(c);
          cur_e = c[0]; cur_x = c[1]; cur_a = c[2];
        end
      end
    end
  endtask

  initial begin
    // R7: idle levels while reset is held
    repeat (4) begin
      @(negedge clk);
      check("R7", "ale in reset", ale_o, 1'b1);
      check("R7", "psen_n in reset", psen_no, 1'b1);
    end
    sweep(96, 0);
    // R7: reset in the middle of a run, with external fetch requested
    @(negedge clk);
    rst = 1'b1;
    code_ext = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R7", "ale mid reset", ale_o, 1'b1);
      check("R7", "psen_n mid reset", psen_no, 1'b1);
    end
    sweep(48, 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule